// File: doc/BRIEF.md
# Keyboard Receive Holding Buffer

This block sits on the host side of a keyboard link. It takes bytes from the keyboard side over a valid/ready handshake and keeps them in a holding register that is one byte deep. It tells the host that a byte has arrived by raising an interrupt request. The host empties the register by reading the data port. That port is a single address, decoded from a host read strobe and an address bus.

When the register is still occupied, the block does not overwrite it and does not raise a second interrupt. It holds off the keyboard side with a retry indication, and the keyboard side must offer the byte again later. A handler that acknowledges the interrupt but never reads the data port therefore sees only the first byte. After that, every further byte is refused until the port is read.

A read and a new arrival may fall in the same cycle. The read returns the old byte and the new byte takes its place, so the register stays occupied. The interrupt is a level that follows the occupied flag by default. A parameter can select a one-cycle pulse for each accepted byte instead.

Top module: `kbd_rx_buffer`

## Requirements
- R1: After a synchronous active-low reset, buf_full, irq and kb_retry are 0 and kb_ready is 1.
- R2: While the register is empty, kb_ready is 1. A cycle with kb_valid high accepts kb_data, and buf_full is 1 from the next cycle on.
- R3: With IRQ_PULSE=0 (default), irq is 1 exactly while buf_full is 1. It rises in the cycle after an accept and falls in the cycle after the read that empties the register.
- R4: A cycle with host_rd=1 and host_addr equal to DATA_ADDR (default 8'h60) is a data-port read. In that cycle host_rdata shows the held byte. If nothing is accepted in that cycle, buf_full is 0 from the next cycle on.
- R5: If kb_valid is 1 while the register is full and no data-port read happens in that cycle, then kb_ready is 0, kb_retry is 1, and the held byte is unchanged. A later read shows this when it returns the original byte.
- R6: A refused byte never raises irq. irq stays high across refusals, and after the register is read irq stays low even though refused bytes were offered earlier.
- R7: A read with host_rd=0, or with host_addr different from DATA_ADDR, leaves buf_full and the held byte unchanged.
- R8: When an accept and a data-port read fall in the same cycle, kb_ready is 1 and kb_retry is 0. host_rdata returns the old byte, the new byte is stored, and buf_full stays 1.
- R9: kb_retry is 1 only in cycles where kb_valid is 1.
- R10: host_rdata is 0 in every cycle that is not a data-port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kb_valid | input | 1 | Keyboard side offers a byte |
| kb_data | input | DATA_W | Offered byte |
| kb_ready | output | 1 | Byte is taken this cycle when kb_valid is high |
| kb_retry | output | 1 | Offered byte is refused; the keyboard side must offer it again |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host port address |
| host_rdata | output | DATA_W | Read data, valid during a data-port read |
| buf_full | output | 1 | Holding register occupied |
| irq | output | 1 | Byte-received interrupt request |

## Verification
Every cycle, the assertions check the handshake relations: a refusal only with an offer, and only against a full register with no read in that cycle. They also check that an accept fills the register, that a lone data-port read empties it, and that irq follows buf_full and can only rise after an accept. Some behaviour is visible only over a sequence of cycles, so only the bench scenarios can show it. This covers a refused byte leaving the held value intact, the same-cycle read and accept swapping old for new byte, and reads at foreign addresses having no effect. The random mix of offers, reads and addresses is compared cycle by cycle against a reference model in the bench.

// File: rtl/kbr_pkg.sv
// Package: shared types for the keyboard receive holding buffer.
// Assumes nothing beyond a single clock domain.
package kbr_pkg;

    // Handshake decision for one cycle.
    typedef struct packed {
        logic take;    // offered byte is written into the register
        logic refuse;  // offered byte is turned away, retry requested
    } kbr_hs_t;

    localparam int unsigned KBR_DEF_DATA_W = 8;
    localparam int unsigned KBR_DEF_ADDR_W = 8;

endpackage

// File: rtl/kbr_accept_ctrl.sv
// Module: decides per cycle whether an offered byte is taken or refused.
// Assumes rd_free is high only during a data-port read of a full register.
module kbr_accept_ctrl
    import kbr_pkg::*;
(
    input  logic    kb_valid,
    input  logic    buf_full,
    input  logic    rd_free,
    output logic    ready,
    output kbr_hs_t hs
);

    // Room exists when empty or when the current byte leaves this cycle.
    always_comb begin
        ready     = !buf_full || rd_free;
        hs.take   = kb_valid && ready;
        hs.refuse = kb_valid && !ready;
    end

endmodule

// File: rtl/kbr_byte_store.sv
// Module: one-byte holding register with an occupied flag.
// Assumes load and drain may coincide; load then wins and the flag stays set.
module kbr_byte_store #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drain,
    output logic              full,
    output logic [DATA_W-1:0] held
);

    // Occupied flag: set on load, cleared on a drain without a load.
    always_ff @(posedge clk) begin
        if (!rst_n)     full <= 1'b0;
        else if (load)  full <= 1'b1;
        else if (drain) full <= 1'b0;
    end

    // Data register: captures only on an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= load_data;
    end

endmodule

// File: rtl/kbr_irq_gen.sv
// Module: interrupt request generator, level or pulse variant.
// Assumes load marks each accepted byte and full is the occupied flag.
module kbr_irq_gen #(
    parameter bit IRQ_PULSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic full,
    output logic irq
);

    generate
        if (IRQ_PULSE) begin : g_pulse
            logic pulse_q;
            // One-cycle pulse after each accepted byte.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse_q <= 1'b0;
                else        pulse_q <= load;
            end
            assign irq = pulse_q;
        end else begin : g_level
            // Level request follows the occupied flag.
            assign irq = full;
        end
    endgenerate

endmodule

// File: rtl/kbd_rx_buffer.sv
// Module: top of the keyboard receive holding buffer.
// Takes bytes over valid/ready, holds one, raises irq, frees on a data-port read.
// Assumes host_addr is stable while host_rd is high.
module kbd_rx_buffer
    import kbr_pkg::*;
#(
    parameter int unsigned DATA_W    = KBR_DEF_DATA_W,
    parameter int unsigned ADDR_W    = KBR_DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60,
    parameter bit          IRQ_PULSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_data,
    output logic              kb_ready,
    output logic              kb_retry,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              buf_full,
    output logic              irq
);

    logic              port_hit;
    logic              rd_free;
    logic [DATA_W-1:0] held;
    kbr_hs_t           hs;

    // Data-port decode and the release of an occupied register.
    always_comb begin
        port_hit = host_rd && (host_addr == DATA_ADDR);
        rd_free  = port_hit && buf_full;
    end

    kbr_accept_ctrl u_accept (
        .kb_valid (kb_valid),
        .buf_full (buf_full),
        .rd_free  (rd_free),
        .ready    (kb_ready),
        .hs       (hs)
    );

    kbr_byte_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hs.take),
        .load_data (kb_data),
        .drain     (port_hit),
        .full      (buf_full),
        .held      (held)
    );

    kbr_irq_gen #(.IRQ_PULSE(IRQ_PULSE)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hs.take),
        .full  (buf_full),
        .irq   (irq)
    );

    // Retry to the keyboard side and the read-data mux.
    always_comb begin
        kb_retry   = hs.refuse;
        host_rdata = port_hit ? held : '0;
    end

endmodule

// File: rtl/kbr_checker.sv
// Module: cycle-level properties of kbd_rx_buffer, attached through bind.
// Assumes it sees only the top-level ports.
module kbr_checker #(
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60,
    parameter bit          IRQ_PULSE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kb_valid,
    input logic              kb_ready,
    input logic              kb_retry,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic              buf_full,
    input logic              irq
);

    logic hit;
    logic took;
    // Port-level view of a data-port read and an accepted byte.
    always_comb begin
        hit  = host_rd && (host_addr == DATA_ADDR);
        took = kb_valid && kb_ready;
    end

    a_r2_full_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> buf_full);

    a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !took) |=> !buf_full);

    a_r5_refuse_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        kb_retry |-> (buf_full && !kb_ready && !hit));

    a_r5_refuse_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        kb_retry |=> buf_full);

    a_r9_retry_needs_offer: assert property (@(posedge clk) disable iff (!rst_n)
        kb_retry |-> kb_valid);

    a_r6_irq_rise_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(took));

    generate
        if (!IRQ_PULSE) begin : g_lvl
            a_r3_irq_follows_full: assert property (@(posedge clk) disable iff (!rst_n)
                irq == buf_full);
        end else begin : g_pls
            a_r3_pulse_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
                irq |-> buf_full);
        end
    endgenerate

endmodule

bind kbd_rx_buffer kbr_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_ADDR (DATA_ADDR),
    .IRQ_PULSE (IRQ_PULSE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .kb_valid  (kb_valid),
    .kb_ready  (kb_ready),
    .kb_retry  (kb_retry),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .buf_full  (buf_full),
    .irq       (irq)
);

// File: tb/kbd_rx_buffer_tb_top.sv
// Bench: directed corners plus seeded random traffic against a reference model.
module kbd_rx_buffer_tb_top;

    localparam int unsigned DW = 8;
    localparam int unsigned AW = 8;
    localparam logic [7:0]  PORT = 8'h60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kb_valid = 1'b0;
    logic [DW-1:0] kb_data = '0;
    logic          kb_ready;
    logic          kb_retry;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_rdata;
    logic          buf_full;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference state.
    bit          m_full = 1'b0;
    logic [DW-1:0] m_byte = '0;

    always #10 clk = ~clk;  // 50 MHz

    kbd_rx_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_data(kb_data),
        .kb_ready(kb_ready), .kb_retry(kb_retry), .host_rd(host_rd),
        .host_addr(host_addr), .host_rdata(host_rdata),
        .buf_full(buf_full), .irq(irq)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit f_hit(logic rd, logic [AW-1:0] a);
        return rd && (a == PORT);
    endfunction

    function automatic bit f_ready(bit full, bit hit);
        return !full || hit;
    endfunction

    // One cycle: drive after negedge, check outputs, update model, cross the edge.
    task automatic step(logic v, logic [DW-1:0] d, logic rd, logic [AW-1:0] a);
        bit hit, rdy, exp_retry;
        kb_valid = v; kb_data = d; host_rd = rd; host_addr = a;
        #1;
        hit = f_hit(rd, a);
        rdy = f_ready(m_full, hit && m_full);
        exp_retry = v && !rdy;
        check("R2", "buf_full", buf_full, m_full);
        check("R3", "irq", irq, m_full);
        check(exp_retry ? "R5" : "R8", "kb_ready", kb_ready, rdy);
        check("R9", "kb_retry", kb_retry, exp_retry);
        check(hit ? "R4" : "R10", "host_rdata", host_rdata, hit ? m_byte : '0);
        if (v && rdy) begin m_full = 1'b1; m_byte = d; end
        else if (hit)  m_full = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h5eed_0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "buf_full", buf_full, 0);
        check("R1", "irq", irq, 0);
        check("R1", "kb_retry", kb_retry, 0);
        check("R1", "kb_ready", kb_ready, 1);
        rst_n = 1'b1;

        // R2/R3: accept into empty
        step(1, 8'h1c, 0, PORT);
        check("R2", "full after accept", buf_full, 1);
        check("R3", "irq after accept", irq, 1);
        // R5/R6: refused bytes while full, no read
        step(1, 8'h32, 0, PORT);
        step(1, 8'h44, 0, 8'h00);
        check("R6", "irq held across refusal", irq, 1);
        // R7: foreign address and strobe-less reads ignored
        step(0, 8'h00, 1, 8'h64);
        step(0, 8'h00, 0, PORT);
        check("R7", "full after foreign read", buf_full, 1);
        // R4/R5: read returns original byte
        step(0, 8'h00, 1, PORT);
        check("R4", "empty after read", buf_full, 0);
        check("R6", "irq low after read", irq, 0);
        step(0, 8'h00, 0, PORT);
        check("R6", "no pending irq", irq, 0);
        // R8: simultaneous accept and read
        step(1, 8'h5a, 0, PORT);
        step(1, 8'ha5, 1, PORT);
        check("R8", "full after swap", buf_full, 1);
        step(0, 8'h00, 1, PORT);
        check("R8", "empty after second read", buf_full, 0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic v, rd;
            logic [AW-1:0] a;
            v  = ($urandom % 3) != 0;
            rd = ($urandom % 3) == 0;
            a  = (($urandom % 4) != 0) ? PORT : AW'($urandom);
            step(v, DW'($urandom), rd, a);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule